// File: doc/BRIEF.md
# Packet Framer and Address Filter

This block sits between the game logic and the byte streams of a 2.4 GHz radio's transmit and receive FIFOs. On the transmit side it takes one 32-bit message and a destination node address from the user side. It then sends the frame body to the SPI sequencer's FIFO-write stream. The body is a length byte, the destination, this node's own address as the source, the four payload bytes with the most significant byte first, and two zero bytes. The radio fills in those two zero bytes with the checksum. It also adds the preamble and the start delimiter by itself, so the framer never writes them.

On the receive side the block reads the byte stream pulled out of the radio's receive FIFO and checks each frame. A frame is kept only when its length is right, its destination is this node or the broadcast address, and its source is a real node. Kept frames go into a small FIFO of filtered messages. The user side drains that FIFO with a ready/start handshake. Any frame that fails the checks is still consumed byte by byte, with the length byte setting how many bytes follow. Because of this, stray traffic such as Wi-Fi frames or frames from a neighbouring channel never leaves the parser out of step with the stream.

Node addresses are 8 bits wide. Address 0x00 never names a node, and 0xFF is the broadcast address. The node's own address is a live input, so it can be changed without a reset.

Top module: `pkt_framer`

## Requirements
- R1: A transmitted frame is exactly 9 bytes, in this order: the length value 8 (the number of bytes after the length byte), the destination, the node address sampled when `tx_start` is accepted, the payload from bits 31:24 down to bits 7:0, then two 0x00 bytes.
- R2: `tx_ready` is high while no frame is being sent. A `tx_start` seen while `tx_ready` is high starts a frame and drives `tx_ready` low until the last byte is accepted. A byte moves when `txb_valid` and `txb_ready` are both high. While `txb_valid` is high and `txb_ready` is low, `txb_valid` and `txb_data` hold.
- R3: A received frame with length byte 8, a destination equal to `my_addr` and a nonzero source is delivered: `rx_data` holds the four payload bytes, the first one received in bits 31:24, and `rx_src` holds the source byte.
- R4: A frame whose destination is 0xFF and whose source is nonzero is delivered whatever `my_addr` is.
- R5: A length-8 frame whose destination is neither `my_addr` nor 0xFF is dropped. The byte that follows its eighth body byte is taken as a new length byte.
- R6: A length-8 frame whose source is 0x00 is dropped.
- R7: A length byte L other than 8 makes the block throw away exactly the next L bytes, and then read a new length byte. A length byte of 0 throws away nothing.
- R8: A frame whose destination is 0x00 is never delivered.
- R9: A change of `my_addr` between frames applies to the next frame with no reset.
- R10: Delivered frames come out in the order they arrived. Up to FIFO_DEPTH (default 4) frames are held. A frame that completes while the FIFO is full is dropped. `rx_ready` is high exactly while a frame is held, and `rx_start` with `rx_ready` high removes the oldest frame.
- R11: After reset, `tx_ready` is 1, `txb_valid` is 0 and `rx_ready` is 0.
- R12: While `rx_ready` is high and `rx_start` is low, `rx_data` and `rx_src` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| my_addr | input | 8 | This node's address, changeable at run time |
| tx_start | input | 1 | Start sending a frame (used only while tx_ready is high) |
| tx_dest | input | 8 | Destination address for the frame being started |
| tx_data | input | 32 | Payload for the frame being started |
| tx_ready | output | 1 | Framer idle, can accept tx_start |
| txb_valid | output | 1 | A frame byte is offered on txb_data |
| txb_data | output | 8 | Frame byte toward the FIFO-write stream |
| txb_ready | input | 1 | The sequencer takes the offered byte this cycle |
| rxb_valid | input | 1 | A received byte is on rxb_data |
| rxb_data | input | 8 | Byte read from the radio's receive FIFO |
| rx_ready | output | 1 | A filtered frame is available |
| rx_start | input | 1 | Remove the oldest filtered frame |
| rx_data | output | 32 | Payload of the oldest filtered frame |
| rx_src | output | 8 | Source address of the oldest filtered frame |

## Verification
The assertions assume the user side follows the handshakes. `tx_start` is raised only while `tx_ready` is high, and `rx_start` only while `rx_ready` is high. `my_addr` stays constant inside a received frame, and every input is free of X once reset is released. The stimulus holds to these rules by construction. It waits for `tx_ready` before pulsing `tx_start`, pops only after it has seen `rx_ready`, and changes `my_addr` only between frames. The randomness goes into the frame kinds, the payloads, the junk lengths, the idle gaps on the receive stream and the back-pressure on `txb_ready`.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
   localparam int          BYTE_W     = 8;
   localparam logic [7:0]  BCAST_ADDR = 8'hFF;
   localparam logic [7:0]  NULL_ADDR  = 8'h00;

   typedef enum logic [2:0] {
      RX_LEN,
      RX_DEST,
      RX_SRC,
      RX_PAY,
      RX_CRC,
      RX_SKIP
   } rx_state_e;

   typedef struct packed {
      logic [7:0]  src;
      logic [31:0] data;
   } rx_msg_t;
endpackage

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
   parameter int DATA_W    = 32,
   parameter int CRC_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        my_addr,
   input  logic              tx_start,
   input  logic [7:0]        tx_dest,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              txb_valid,
   output logic [7:0]        txb_data,
   input  logic              txb_ready
);
   localparam int PAY_BYTES   = DATA_W / 8;
   localparam int FRAME_BYTES = 3 + PAY_BYTES + CRC_BYTES;
   localparam int FRAME_W     = FRAME_BYTES * 8;
   localparam int LEN_VAL     = FRAME_BYTES - 1;
   localparam int CNT_W       = $clog2(FRAME_BYTES + 1);

   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] frame_img;
   logic [CNT_W-1:0]   left;
   logic               busy;

   always_comb begin
      frame_img = {8'(LEN_VAL), tx_dest, my_addr, tx_data, {(CRC_BYTES*8){1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         busy  <= 1'b0;
         left  <= '0;
         shreg <= '0;
      end else if (!busy) begin
         if (tx_start) begin
            busy  <= 1'b1;
            left  <= CNT_W'(FRAME_BYTES);
            shreg <= frame_img;
         end
      end else if (txb_ready) begin
         shreg <= shreg << 8;
         left  <= left - 1'b1;
         if (left == CNT_W'(1)) busy <= 1'b0;
      end
   end

   assign tx_ready  = !busy;
   assign txb_valid = busy;
   assign txb_data  = shreg[FRAME_W-1 -: 8];
endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
   import pkt_framer_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int CRC_BYTES    = 2,
   parameter bit ACCEPT_BCAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        my_addr,
   input  logic              rxb_valid,
   input  logic [7:0]        rxb_data,
   output logic              push,
   output logic [7:0]        push_src,
   output logic [DATA_W-1:0] push_data
);
   localparam int PAY_BYTES   = DATA_W / 8;
   localparam int FRAME_BYTES = 3 + PAY_BYTES + CRC_BYTES;
   localparam int LEN_VAL     = FRAME_BYTES - 1;

   rx_state_e         state;
   logic [7:0]        cnt;
   logic              keep;
   logic              addr_hit;
   logic              bcast_hit;
   logic [7:0]        src_q;
   logic [DATA_W-1:0] data_q;

   generate
      if (ACCEPT_BCAST) begin : g_bcast
         assign bcast_hit = (rxb_data == BCAST_ADDR);
      end else begin : g_unicast
         assign bcast_hit = 1'b0;
      end
   endgenerate

   assign addr_hit = (rxb_data != NULL_ADDR) && ((rxb_data == my_addr) || bcast_hit);

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= RX_LEN;
         cnt    <= '0;
         keep   <= 1'b0;
         src_q  <= '0;
         data_q <= '0;
      end else if (rxb_valid) begin
         unique case (state)
            RX_LEN: begin
               cnt <= rxb_data;
               if (rxb_data == 8'(LEN_VAL)) state <= RX_DEST;
               else if (rxb_data != 8'd0)   state <= RX_SKIP;
            end
            RX_SKIP: begin
               cnt <= cnt - 8'd1;
               if (cnt == 8'd1) state <= RX_LEN;
            end
            RX_DEST: begin
               keep  <= addr_hit;
               state <= RX_SRC;
            end
            RX_SRC: begin
               keep  <= keep && (rxb_data != NULL_ADDR);
               src_q <= rxb_data;
               cnt   <= '0;
               state <= RX_PAY;
            end
            RX_PAY: begin
               data_q <= {data_q[DATA_W-9:0], rxb_data};
               if (cnt == 8'(PAY_BYTES - 1)) begin
                  cnt   <= '0;
                  state <= RX_CRC;
               end else begin
                  cnt <= cnt + 8'd1;
               end
            end
            RX_CRC: begin
               if (cnt == 8'(CRC_BYTES - 1)) begin
                  cnt   <= '0;
                  state <= RX_LEN;
               end else begin
                  cnt <= cnt + 8'd1;
               end
            end
            default: state <= RX_LEN;
         endcase
      end
   end

   assign push      = rxb_valid && (state == RX_CRC) && (cnt == 8'(CRC_BYTES - 1)) && keep;
   assign push_src  = src_q;
   assign push_data = data_q;
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
   parameter int WIDTH = 40,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             not_empty
);
   generate
      if (DEPTH == 1) begin : g_single
         logic [WIDTH-1:0] slot;
         logic             full_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               full_q <= 1'b0;
               slot   <= '0;
            end else if (full_q) begin
               if (pop) full_q <= 1'b0;
            end else if (push) begin
               full_q <= 1'b1;
               slot   <= wdata;
            end
         end
         assign rdata     = slot;
         assign not_empty = full_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         logic [WIDTH-1:0] mem [DEPTH];
         logic [PTR_W-1:0] wr_ptr, rd_ptr;
         logic [PTR_W:0]   count;
         logic             do_push, do_pop;

         assign do_pop  = pop && (count != '0);
         assign do_push = push && (count != (PTR_W+1)'(DEPTH));

         always_ff @(posedge clk) begin
            if (rst) begin
               wr_ptr <= '0;
               rd_ptr <= '0;
               count  <= '0;
            end else begin
               if (do_push) wr_ptr <= wr_ptr + 1'b1;
               if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
               if (do_push && !do_pop)      count <= count + 1'b1;
               else if (do_pop && !do_push) count <= count - 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem[wr_ptr] <= wdata;
         end

         assign rdata     = mem[rd_ptr];
         assign not_empty = (count != '0);
      end
   endgenerate
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
   import pkt_framer_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int CRC_BYTES    = 2,
   parameter int FIFO_DEPTH   = 4,
   parameter bit ACCEPT_BCAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [7:0]        my_addr,
   input  logic              tx_start,
   input  logic [7:0]        tx_dest,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              txb_valid,
   output logic [7:0]        txb_data,
   input  logic              txb_ready,
   input  logic              rxb_valid,
   input  logic [7:0]        rxb_data,
   output logic              rx_ready,
   input  logic              rx_start,
   output logic [DATA_W-1:0] rx_data,
   output logic [7:0]        rx_src
);
   localparam int MSG_W = DATA_W + BYTE_W;

   generate
      if (DATA_W % BYTE_W != 0 || DATA_W < 16) begin : g_bad_width
         $error("pkt_framer: DATA_W must be a whole number of bytes, at least two");
      end
      if (CRC_BYTES < 1 || 3 + DATA_W / 8 + CRC_BYTES > 255) begin : g_bad_crc
         $error("pkt_framer: CRC_BYTES out of range");
      end
      if (FIFO_DEPTH < 1 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pkt_framer: FIFO_DEPTH must be a power of two");
      end
   endgenerate

   logic              push;
   logic [7:0]        push_src;
   logic [DATA_W-1:0] push_data;
   logic [MSG_W-1:0]  head;

   pkt_tx_framer #(.DATA_W(DATA_W), .CRC_BYTES(CRC_BYTES)) u_tx (
      .clk       (clk),
      .rst       (rst),
      .my_addr   (my_addr),
      .tx_start  (tx_start),
      .tx_dest   (tx_dest),
      .tx_data   (tx_data),
      .tx_ready  (tx_ready),
      .txb_valid (txb_valid),
      .txb_data  (txb_data),
      .txb_ready (txb_ready)
   );

   pkt_rx_filter #(.DATA_W(DATA_W), .CRC_BYTES(CRC_BYTES), .ACCEPT_BCAST(ACCEPT_BCAST)) u_filt (
      .clk       (clk),
      .rst       (rst),
      .my_addr   (my_addr),
      .rxb_valid (rxb_valid),
      .rxb_data  (rxb_data),
      .push      (push),
      .push_src  (push_src),
      .push_data (push_data)
   );

   pkt_rx_fifo #(.WIDTH(MSG_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (push),
      .wdata     ({push_src, push_data}),
      .pop       (rx_start && rx_ready),
      .rdata     (head),
      .not_empty (rx_ready)
   );

   assign rx_src  = head[MSG_W-1 -: 8];
   assign rx_data = head[DATA_W-1:0];
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk #(
   parameter int DATA_W    = 32,
   parameter int CRC_BYTES = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              tx_start,
   input logic              tx_ready,
   input logic              txb_valid,
   input logic [7:0]        txb_data,
   input logic              txb_ready,
   input logic              rx_ready,
   input logic              rx_start,
   input logic [DATA_W-1:0] rx_data,
   input logic [7:0]        rx_src
);
   localparam int LEN_VAL = 2 + DATA_W / 8 + CRC_BYTES;

   // R1
   tx_len_first_chk: assert property (@(posedge clk) disable iff (rst)
      tx_ready && tx_start |=> txb_valid && (txb_data == 8'(LEN_VAL)));

   // R2
   tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      txb_valid && !txb_ready |=> txb_valid && $stable(txb_data));

   // R12
   rx_head_hold_chk: assert property (@(posedge clk) disable iff (rst)
      rx_ready && !rx_start |=> rx_ready && $stable(rx_data) && $stable(rx_src));

   // R10
   rx_pop_only_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rx_ready) |-> $past(rx_start));
endmodule

bind pkt_framer pkt_framer_chk #(.DATA_W(DATA_W), .CRC_BYTES(CRC_BYTES)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .tx_start  (tx_start),
   .tx_ready  (tx_ready),
   .txb_valid (txb_valid),
   .txb_data  (txb_data),
   .txb_ready (txb_ready),
   .rx_ready  (rx_ready),
   .rx_start  (rx_start),
   .rx_data   (rx_data),
   .rx_src    (rx_src)
);

// File: tb/pkt_framer_test.sv
`timescale 1ns/1ps
module pkt_framer_test;
   localparam int DW    = 32;
   localparam int DEPTH = 4;
   localparam int FB    = 9;

   logic          clk = 1'b0;
   logic          rst;
   logic [7:0]    my_addr;
   logic          tx_start, txb_ready, rxb_valid, rx_start;
   logic [7:0]    tx_dest, rxb_data;
   logic [DW-1:0] tx_data;
   logic          tx_ready, txb_valid, rx_ready;
   logic [7:0]    txb_data, rx_src;
   logic [DW-1:0] rx_data;

   always #4 clk = ~clk;

   pkt_framer uut (
      .clk(clk), .rst(rst), .my_addr(my_addr),
      .tx_start(tx_start), .tx_dest(tx_dest), .tx_data(tx_data), .tx_ready(tx_ready),
      .txb_valid(txb_valid), .txb_data(txb_data), .txb_ready(txb_ready),
      .rxb_valid(rxb_valid), .rxb_data(rxb_data),
      .rx_ready(rx_ready), .rx_start(rx_start), .rx_data(rx_data), .rx_src(rx_src)
   );

   int vectors = 0;
   int errs    = 0;
   logic [39:0] model[$];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit accept(input logic [7:0] d, input logic [7:0] s, input logic [7:0] a);
      return (d != 8'h00) && ((d == a) || (d == 8'hFF)) && (s != 8'h00);
   endfunction

   function automatic logic [7:0] tx_exp(input int i, input logic [7:0] d, input logic [7:0] s,
                                         input logic [31:0] p);
      case (i)
         0: return 8'd8;
         1: return d;
         2: return s;
         3, 4, 5, 6: return p[8*(6-i) +: 8];
         default: return 8'h00;
      endcase
   endfunction

   // all tasks start and end just after a falling edge
   task automatic rx_byte(input logic [7:0] b);
      if ($urandom % 4 == 0) begin
         rxb_valid = 1'b0;
         @(posedge clk); @(negedge clk);
      end
      rxb_valid = 1'b1;
      rxb_data  = b;
      @(posedge clk); @(negedge clk);
      rxb_valid = 1'b0;
   endtask

   task automatic rx_frame(input logic [7:0] d, input logic [7:0] s, input logic [31:0] p);
      rx_byte(8'd8);
      rx_byte(d);
      rx_byte(s);
      for (int i = 3; i >= 0; i--) rx_byte(p[8*i +: 8]);
      rx_byte(8'($urandom));
      rx_byte(8'($urandom));
      if (accept(d, s, my_addr) && model.size() < DEPTH) model.push_back({s, p});
   endtask

   task automatic rx_junk(input logic [7:0] len);
      rx_byte(len);
      for (int i = 0; i < int'(len); i++) rx_byte(8'($urandom));
   endtask

   task automatic drain(input string req);
      chk(rx_ready == (model.size() != 0), req, rx_ready, model.size() != 0);
      while (model.size() > 0) begin
         chk(rx_ready == 1'b1, req, rx_ready, 1);
         chk({rx_src, rx_data} == model[0], req, {rx_src, rx_data}, model[0]);
         rx_start = 1'b1;
         @(posedge clk); @(negedge clk);
         rx_start = 1'b0;
         void'(model.pop_front());
      end
      chk(rx_ready == 1'b0, req, rx_ready, 0);
   endtask

   task automatic tx_frame(input logic [7:0] d, input logic [31:0] p, input bit stall);
      int   idx = 0;
      int   guard = 0;
      bit   held = 1'b0;
      logic [7:0] prev = 8'h00;
      logic [7:0] src = my_addr;
      chk(tx_ready == 1'b1, "R2 idle", tx_ready, 1);
      tx_start = 1'b1; tx_dest = d; tx_data = p;
      @(posedge clk); @(negedge clk);
      tx_start = 1'b0; tx_dest = 8'($urandom); tx_data = $urandom;
      while (idx < FB && guard < 200) begin
         guard++;
         txb_ready = stall ? ($urandom % 3 != 0) : 1'b1;
         #1;
         if (held) chk(txb_data == prev, "R2 hold", txb_data, prev);
         if (!txb_valid || tx_ready) chk(1'b0, "R2 busy", {tx_ready, txb_valid}, 2'b01);
         if (txb_valid && txb_ready) begin
            chk(txb_data == tx_exp(idx, d, src, p), "R1 byte", txb_data, tx_exp(idx, d, src, p));
            idx++;
            held = 1'b0;
         end else begin
            held = 1'b1;
            prev = txb_data;
         end
         @(posedge clk); @(negedge clk);
      end
      txb_ready = 1'b0;
      chk(tx_ready && !txb_valid, "R2 done", {tx_ready, txb_valid}, 2'b10);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      rst = 1'b1; my_addr = 8'h21; tx_start = 1'b0; tx_dest = 8'h00; tx_data = '0;
      txb_ready = 1'b0; rxb_valid = 1'b0; rxb_data = 8'h00; rx_start = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R11
      chk(tx_ready && !txb_valid && !rx_ready, "R11 reset", {tx_ready, txb_valid, rx_ready}, 3'b100);

      // R1 R2 directed
      tx_frame(8'h5C, 32'hA1B2C3D4, 1'b0);
      tx_frame(8'hFF, 32'h01020304, 1'b1);

      // R3 to self
      rx_frame(8'h21, 8'h37, 32'hDEADBEEF);
      // R12 head held several cycles
      repeat (3) begin
         @(posedge clk); @(negedge clk);
         chk(rx_ready && rx_data == 32'hDEADBEEF && rx_src == 8'h37, "R12 hold", rx_data, 32'hDEADBEEF);
      end
      drain("R3 self");
      // R4 broadcast
      rx_frame(8'hFF, 8'h44, 32'h12345678);
      drain("R4 bcast");
      // R5 foreign then good
      rx_frame(8'h22, 8'h10, 32'h11111111);
      chk(rx_ready == 1'b0, "R5 foreign", rx_ready, 0);
      rx_frame(8'h21, 8'h10, 32'h22222222);
      drain("R5 aligned");
      // R6 source zero
      rx_frame(8'h21, 8'h00, 32'h33333333);
      drain("R6 src0");
      // R8 dest zero
      rx_frame(8'h00, 8'h12, 32'h44444444);
      drain("R8 dest0");
      // R7 bad lengths, 0 and 9 and a long one, then good frame
      rx_junk(8'd0);
      rx_junk(8'd9);
      rx_junk(8'd30);
      rx_frame(8'h21, 8'h66, 32'h55AA55AA);
      drain("R7 skip");
      // R9 address change
      my_addr = 8'h5A;
      rx_frame(8'h21, 8'h01, 32'h66666666);
      rx_frame(8'h5A, 8'h02, 32'h77777777);
      drain("R9 readdr");
      // R10 overflow
      for (int i = 0; i < DEPTH + 2; i++) rx_frame(8'h5A, 8'(i + 1), 32'hC0DE0000 + i);
      drain("R10 full");

      // random mix
      for (int n = 0; n < 160; n++) begin
         int kind = $urandom % 8;
         logic [7:0]  s = 8'($urandom);
         logic [31:0] p = $urandom;
         case (kind)
            0, 1: rx_frame(my_addr, s, p);
            2:    rx_frame(8'hFF, s, p);
            3:    rx_frame(8'($urandom), s, p);
            4:    rx_frame(my_addr, 8'h00, p);
            5:    begin
                     logic [7:0] l = 8'($urandom % 24);
                     if (l == 8'd8) l = 8'd5;
                     rx_junk(l);
                  end
            6:    tx_frame(8'($urandom), p, 1'b1);
            default: begin
                     my_addr = 8'($urandom % 255) + 8'd1;
                  end
         endcase
         if ($urandom % 3 == 0) drain("R10 random");
      end
      drain("R3 final");

      summary();
      $finish;
   end
endmodule